// File: doc/BRIEF.md
# Interrupt Request Priority and Acknowledge Core

This block is the request and service engine of an eight-line interrupt controller. It watches eight level inputs and turns each rising transition on an unmasked line into a pending request. Every request goes through a fixed priority check against the lines already being serviced. When a request may go through, the core sends a one-cycle pulse to the processor. The line with the highest index has the highest priority.

When the processor acknowledges, the core picks the highest pending line and clears its pending bit. It then either marks the line as in service or, with automatic end-of-interrupt on, retires it at once. The core registers a vector, formed from a base value and the line index, and raises a cascade-forward flag when the winning line belongs to a downstream controller. End-of-interrupt pulses retire in-service lines, either the highest one or a named one. After every retirement the core checks the pending set again, so that a request held back until now can reach the processor.

The mask, the vector base, the cascade map and the auto-EOI setting come from a separate register block and are plain inputs here.

Top module: `irq_core`

## Requirements
- R1: A rising transition on line n (irq_i[n] low in one cycle and high at the next clock edge), with mask_i[n]=0, sets pending_o[n] after that edge.
- R2: A rising transition on a line whose mask_i bit is 1 is discarded. Clearing the mask bit afterwards does not create a request while the line stays high.
- R3: A line that stays high produces no further request, even after its pending bit has been acknowledged away. A new request needs the line to go low and rise again.
- R4: int_o is a registered pulse, high for the one cycle after a new request on line n when in_service_o[7:n] are all zero. A request on a line at or below the highest in-service line does not pulse int_o.
- R5: An ack_i cycle with pending bits set picks the highest set pending bit w. It clears pending_o[w] and sets in_service_o[w]. After the same edge, vector_o equals vec_base_i OR w.
- R6: With auto_eoi_i=1, an acknowledge clears the winner's pending bit and leaves in_service_o unchanged.
- R7: After an acknowledge, cascade_fwd_o equals cascade_map_i[w] and holds until the next acknowledge.
- R8: An acknowledge with pending_o zero sets vector_o to vec_base_i OR 7 and cascade_fwd_o to 0, and leaves pending_o and in_service_o unchanged.
- R9: eoi_i with eoi_specific_i=0 clears the highest set in-service bit. eoi_i with eoi_specific_i=1 clears in_service_o[eoi_line_i].
- R10: After any end-of-interrupt, including the automatic one, int_o pulses if a pending bit remains and the highest pending line p has in_service_o[7:p] all zero after the retirement.
- R11: After reset, pending_o, in_service_o, int_o, vector_o and cascade_fwd_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request levels |
| mask_i | input | 8 | Per-line mask, 1 discards edges |
| vec_base_i | input | 8 | Vector base, OR-ed with the line index |
| cascade_map_i | input | 8 | Lines served by a downstream controller |
| auto_eoi_i | input | 1 | Retire on acknowledge instead of marking in service |
| ack_i | input | 1 | Acknowledge strobe, one cycle |
| eoi_i | input | 1 | End-of-interrupt strobe, one cycle |
| eoi_specific_i | input | 1 | 1: retire eoi_line_i, 0: retire highest in-service line |
| eoi_line_i | input | 3 | Line to retire for a specific EOI |
| pending_o | output | 8 | Pending request bits |
| in_service_o | output | 8 | In-service bits |
| int_o | output | 1 | Interrupt pulse to the processor |
| vector_o | output | 8 | Vector of the last acknowledge |
| cascade_fwd_o | output | 1 | Last winner belongs to a downstream controller |

## Verification
The hardest case to reach is the deferred forward. A request has to sit pending behind a higher in-service line, without any pulse, until an end-of-interrupt releases it. The bench sets this up by servicing a line, raising a lower line and then a higher one, and then retiring the serviced line. It checks that the pulse comes only at the retirement. The automatic variant is reached by raising two lines in the same cycle with auto-EOI on, so that acknowledging the first one must pulse for the second at once.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;
  typedef enum logic {
    EOI_TOP  = 1'b0,
    EOI_LINE = 1'b1
  } eoi_kind_e;
endpackage

// File: rtl/irq_edge.sv
module irq_edge #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/irq_msb.sv
module irq_msb #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (vec_i[i]) idx_o = IDX_W'(i);
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/irq_core.sv
module irq_core #(
  parameter int N     = 8,
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     irq_i,
  input  logic [N-1:0]     mask_i,
  input  logic [VEC_W-1:0] vec_base_i,
  input  logic [N-1:0]     cascade_map_i,
  input  logic             auto_eoi_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  input  logic             eoi_specific_i,
  input  logic [$clog2(N)-1:0] eoi_line_i,
  output logic [N-1:0]     pending_o,
  output logic [N-1:0]     in_service_o,
  output logic             int_o,
  output logic [VEC_W-1:0] vector_o,
  output logic             cascade_fwd_o
);
  import irq_core_pkg::*;

  localparam int IDX_W = $clog2(N);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]     pend_q, isr_q, pend_d, isr_d;
  logic [N-1:0]     rise, new_req;
  logic [IDX_W-1:0] pend_idx, isr_idx, next_idx;
  logic             pend_any, isr_any, next_any;
  logic [N-1:0]     free_q, free_d;
  logic [N-1:0]     ack_hot, eoi_hot;
  logic             ack_hit, eoi_evt, fwd_new, fwd_eoi;
  logic             int_q, casc_q;
  logic [VEC_W-1:0] vec_q;
  eoi_kind_e        eoi_kind;

  irq_edge #(.N(N)) u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(irq_i), .rise_o(rise)
  );

  irq_msb #(.N(N)) u_pend_msb (.vec_i(pend_q), .idx_o(pend_idx), .any_o(pend_any));
  irq_msb #(.N(N)) u_isr_msb  (.vec_i(isr_q),  .idx_o(isr_idx),  .any_o(isr_any));
  irq_msb #(.N(N)) u_next_msb (.vec_i(pend_d), .idx_o(next_idx), .any_o(next_any));

  // free_x[n]: no in-service bit at or above n
  for (genvar n = 0; n < N; n++) begin : g_free
    assign free_q[n] = ~|isr_q[N-1:n];
    assign free_d[n] = ~|isr_d[N-1:n];
  end

  assign new_req  = rise & ~mask_i;
  assign ack_hit  = ack_i & pend_any;
  assign ack_hot  = ack_hit ? (ONE << pend_idx) : '0;
  assign eoi_kind = eoi_kind_e'(eoi_specific_i);

  always_comb begin
    eoi_hot = '0;
    if (eoi_i) begin
      if (eoi_kind == EOI_LINE) eoi_hot = ONE << eoi_line_i;
      else if (isr_any)         eoi_hot = ONE << isr_idx;
    end
  end

  assign pend_d  = (pend_q & ~ack_hot) | new_req;
  assign isr_d   = (isr_q | (auto_eoi_i ? '0 : ack_hot)) & ~eoi_hot;
  assign eoi_evt = eoi_i | (ack_hit & auto_eoi_i);
  assign fwd_new = |(new_req & free_q);
  assign fwd_eoi = eoi_evt & next_any & free_d[next_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      isr_q  <= '0;
      int_q  <= 1'b0;
      vec_q  <= '0;
      casc_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      isr_q  <= isr_d;
      int_q  <= fwd_new | fwd_eoi;
      if (ack_i) begin
        if (pend_any) begin
          vec_q  <= vec_base_i | {{(VEC_W-IDX_W){1'b0}}, pend_idx};
          casc_q <= cascade_map_i[pend_idx];
        end else begin
          vec_q  <= vec_base_i | {{(VEC_W-IDX_W){1'b0}}, {IDX_W{1'b1}}};
          casc_q <= 1'b0;
        end
      end
    end
  end

  assign pending_o     = pend_q;
  assign in_service_o  = isr_q;
  assign int_o         = int_q;
  assign vector_o      = vec_q;
  assign cascade_fwd_o = casc_q;
endmodule

// File: rtl/irq_core_chk.sv
module irq_core_chk #(
  parameter int N     = 8,
  parameter int VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N-1:0]     mask_i,
  input logic [VEC_W-1:0] vec_base_i,
  input logic             auto_eoi_i,
  input logic             ack_i,
  input logic [N-1:0]     pending_o,
  input logic [N-1:0]     in_service_o,
  input logic [VEC_W-1:0] vector_o,
  input logic             cascade_fwd_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R2
  masked_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((pending_o & ~$past(pending_o) & $past(mask_i)) == '0));

  // R5
  isr_only_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !ack_i |=> ((in_service_o & ~$past(in_service_o)) == '0));

  // R6
  auto_eoi_no_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && ack_i && auto_eoi_i |=> ((in_service_o & ~$past(in_service_o)) == '0));

  // R8
  empty_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && ack_i && pending_o == '0 |=>
      (vector_o == ($past(vec_base_i) | VEC_W'(N-1))) && !cascade_fwd_o && $stable(in_service_o));

  // R7
  casc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !ack_i |=> $stable(cascade_fwd_o) && $stable(vector_o));
endmodule

bind irq_core irq_core_chk #(.N(N), .VEC_W(VEC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mask_i       (mask_i),
  .vec_base_i   (vec_base_i),
  .auto_eoi_i   (auto_eoi_i),
  .ack_i        (ack_i),
  .pending_o    (pending_o),
  .in_service_o (in_service_o),
  .vector_o     (vector_o),
  .cascade_fwd_o(cascade_fwd_o)
);

// File: tb/irq_core_test.sv
`timescale 1ns/1ps
module irq_core_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] irq_i = '0, mask_i = '0, vec_base_i = '0, cascade_map_i = '0;
  logic       auto_eoi_i = 1'b0, ack_i = 1'b0, eoi_i = 1'b0, eoi_specific_i = 1'b0;
  logic [2:0] eoi_line_i = '0;
  logic [7:0] pending_o, in_service_o, vector_o;
  logic       int_o, cascade_fwd_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  irq_core uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock, then settle at the falling edge
  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic ack();
    ack_i = 1'b1; step(); ack_i = 1'b0;
  endtask

  task automatic eoi(input bit spec, input logic [2:0] ln);
    eoi_i = 1'b1; eoi_specific_i = spec; eoi_line_i = ln; step(); eoi_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 pending", pending_o, 0);
    chk("R11 in_service", in_service_o, 0);
    chk("R11 int", int_o, 0);
    chk("R11 vector", vector_o, 0);
    chk("R11 cascade", cascade_fwd_o, 0);
  endtask

  task automatic t_basic();
    vec_base_i = 8'h20;
    irq_i[3] = 1'b1; step();
    chk("R1 pending", pending_o, 8'h08);
    chk("R4 pulse", int_o, 1);
    step();
    chk("R4 pulse ends", int_o, 0);
    irq_i[3] = 1'b0;
    ack();
    chk("R5 pending cleared", pending_o, 0);
    chk("R5 in_service", in_service_o, 8'h08);
    chk("R5 vector", vector_o, 8'h23);
    chk("R7 no cascade", cascade_fwd_o, 0);
  endtask

  task automatic t_blocked_then_eoi();
    irq_i[2] = 1'b1; step();
    chk("R4 blocked pending", pending_o, 8'h04);
    chk("R4 blocked no pulse", int_o, 0);
    irq_i[5] = 1'b1; step();
    chk("R4 higher pulse", int_o, 1);
    step();
    eoi(1'b0, 3'd0);
    chk("R9 top eoi", in_service_o, 0);
    chk("R10 refire", int_o, 1);
    ack();
    chk("R5 winner 5", vector_o, 8'h25);
    chk("R5 pending left", pending_o, 8'h04);
    ack();
    chk("R5 winner 2", in_service_o, 8'h24);
    eoi(1'b1, 3'd5);
    chk("R9 specific eoi", in_service_o, 8'h04);
    chk("R10 nothing pending", int_o, 0);
    eoi(1'b0, 3'd0);
    chk("R9 top eoi empty", in_service_o, 0);
    irq_i = '0; step();
  endtask

  task automatic t_hold();
    irq_i[1] = 1'b1; step();
    chk("R3 first", pending_o, 8'h02);
    ack();
    repeat (4) step();
    chk("R3 held high", pending_o, 0);
    irq_i[1] = 1'b0; step();
    irq_i[1] = 1'b1; step();
    chk("R3 re-rise", pending_o, 8'h02);
    ack(); eoi(1'b0, 3'd0); eoi(1'b0, 3'd0);
    irq_i = '0; step();
    chk("R9 clean", in_service_o, 0);
  endtask

  task automatic t_mask();
    mask_i = 8'h80;
    irq_i[7] = 1'b1; step();
    chk("R2 masked", pending_o, 0);
    chk("R2 no pulse", int_o, 0);
    mask_i = 8'h00; repeat (3) step();
    chk("R2 not remembered", pending_o, 0);
    irq_i[7] = 1'b0; step();
    irq_i[7] = 1'b1; step();
    chk("R1 after unmask", pending_o, 8'h80);
  endtask

  task automatic t_cascade_empty();
    cascade_map_i = 8'h80;
    ack();
    chk("R7 cascade", cascade_fwd_o, 1);
    chk("R5 vector 7", vector_o, 8'h27);
    step();
    chk("R7 held", cascade_fwd_o, 1);
    vec_base_i = 8'h40;
    ack();
    chk("R8 vector", vector_o, 8'h47);
    chk("R8 cascade", cascade_fwd_o, 0);
    chk("R8 in_service", in_service_o, 8'h80);
    chk("R8 pending", pending_o, 0);
    eoi(1'b0, 3'd0);
    irq_i = '0; cascade_map_i = '0; step();
  endtask

  task automatic t_auto();
    auto_eoi_i = 1'b1;
    irq_i = 8'h50; step();
    chk("R1 two lines", pending_o, 8'h50);
    chk("R4 pulse", int_o, 1);
    step();
    ack();
    chk("R6 pending", pending_o, 8'h10);
    chk("R6 in_service", in_service_o, 0);
    chk("R5 vector 6", vector_o, 8'h46);
    chk("R10 auto refire", int_o, 1);
    ack();
    chk("R6 last", pending_o, 0);
    chk("R10 no refire", int_o, 0);
    auto_eoi_i = 1'b0; irq_i = '0; step();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_blocked_then_eoi();
    t_hold();
    t_mask();
    t_cascade_empty();
    t_auto();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule